// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block turns a simple synchronous host request port into the pin sequences needed by an asynchronous, byte-wide static RAM. The RAM has two chip selects of opposite polarity, an active-low output enable, an active-low write strobe and a shared data bus. On the chip side the bus is split into an output value, an output enable and an input value. The controller accepts one read or one write at a time while it is idle. It counts clock cycles so that each access meets the minimum and maximum times of the chosen speed grade. It then returns a one-cycle completion pulse and, for reads, the sampled byte.

Two parameters shape the timing. `CLK_NS` gives the clock period in nanoseconds. `GRADE` selects the device speed: 0 for 45 ns, 1 for 55 ns and 2 for 70 ns. Every nanosecond figure is turned into a whole number of cycles by rounding up when the design is elaborated. A host can also park the memory in a low-power retention state, in which it is held deselected. Leaving that state costs a recovery delay of one full read cycle time before the next access is accepted.

Top module: `sram_ctl`

## Requirements
- R1: While reset is high, and on the first edge after it, `mem_cs1_n` is 1, `mem_cs2` is 0, `mem_oe_n` is 1, `mem_we_n` is 1 and `mem_dq_oe` is 0. After reset, `done` and `retained` are 0 and `req_ready` is 1.
- R2: A write selects the chip (`mem_cs1_n`=0, `mem_cs2`=1) for one setup cycle, then holds `mem_we_n` low for WP = max(ceil(tWP/T), ceil(tCW/T)-1, ceil(tAW/T)-1, ceil(tDW/T)) cycles, which is 4 at the defaults. `mem_we_n` is low only while the chip is selected, and the chip is selected for at least ceil(tCW/T) cycles before `mem_we_n` rises.
- R3: `done` rises 1+WP+WR cycles after the edge that accepts a write, where WR = max(1, ceil(tWC/T)-1-WP). This is 6 at the defaults. The addressed location then holds the write data.
- R4: A read holds `mem_oe_n` low, with the chip selected and `mem_we_n` high, for RA = max(ceil(tAA/T), ceil(tOE/T)) cycles. It samples `mem_dq_in` on the last of those edges. `done` follows RR = max(1, ceil(tHZ/T), ceil(tRC/T)-RA) cycles later, so it rises RA+RR cycles after acceptance, which is 8 at the defaults.
- R5: `mem_dq_oe` is high only while `mem_we_n` is low and `mem_oe_n` is high. It has been low for at least one cycle whenever `mem_oe_n` falls.
- R6: `done` lasts exactly one cycle per accepted request. Requests are accepted only while `req_ready` is high. `req_ready` is high only in idle, with the chip deselected. A `req_valid` held while busy starts no access.
- R7: `rdata` keeps the last read byte until the next read completes. Writes do not change it.
- R8: If `retain_req` is high while idle, the next edge sets `retained` to 1 and keeps the chip deselected with `mem_cs1_n`=1 and `mem_cs2`=0. This takes priority over a request presented in the same cycle, and that request is dropped.
- R9: After `retain_req` falls, `retained` clears on the first edge that sees it low. `req_ready` returns ceil(tRC/T) edges later, which is 6 at the defaults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Host byte address |
| req_wdata | input | 8 | Host write byte |
| req_ready | output | 1 | Controller idle and able to accept |
| retain_req | input | 1 | Request low-power retention |
| retained | output | 1 | Memory parked in retention |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read |
| mem_addr | output | 18 | Memory address |
| mem_cs1_n | output | 1 | Active-low chip select |
| mem_cs2 | output | 1 | Active-high chip select |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write strobe |
| mem_dq_out | output | 8 | Byte driven onto the memory bus |
| mem_dq_oe | output | 1 | Drive enable for the memory bus |
| mem_dq_in | input | 8 | Byte seen on the memory bus |

## Verification
The bench builds the controller with its default values: a 10 ns clock and the 55 ns grade. That gives a four-cycle write strobe, a one-cycle write recovery, a six-cycle read access, a two-cycle read float and a six-cycle retention recovery. At this grade the write strobe is set jointly by the pulse width and by the chip-select and address windows less the setup cycle. This lets the bench tell a correct strobe length from a rounding slip of one cycle. Its memory model answers only when the chip is selected with output enable low, so a read sampled too early or with a deselected chip returns the wrong byte.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WSETUP,
        ST_WPULSE,
        ST_WREC,
        ST_RACC,
        ST_RREC,
        ST_RETAIN,
        ST_RECOVER
    } ctl_state_e;

    typedef enum logic [3:0] {
        TP_WCYC, TP_WPULSE, TP_CSEND, TP_ADEND, TP_DSET,
        TP_RCYC, TP_AACC, TP_OEACC, TP_FLOAT
    } tparam_e;

    typedef struct packed {
        logic cs1_n;
        logic cs2;
        logic oe_n;
        logic we_n;
        logic dq_oe;
    } pin_ctl_t;

    localparam pin_ctl_t PINS_PARKED = '{cs1_n: 1'b1, cs2: 1'b0, oe_n: 1'b1, we_n: 1'b1, dq_oe: 1'b0};

    // Nanosecond figures per speed grade: 0 = 45 ns, 1 = 55 ns, 2 = 70 ns.
    function automatic int unsigned grade_ns(int unsigned grade, tparam_e p);
        int unsigned v;
        v = 0;
        if (grade == 0) begin
            case (p)
                TP_WCYC:   v = 45;
                TP_WPULSE: v = 35;
                TP_CSEND:  v = 45;
                TP_ADEND:  v = 45;
                TP_DSET:   v = 15;
                TP_RCYC:   v = 45;
                TP_AACC:   v = 45;
                TP_OEACC:  v = 25;
                TP_FLOAT:  v = 20;
                default:   v = 0;
            endcase
        end else if (grade == 1) begin
            case (p)
                TP_WCYC:   v = 55;
                TP_WPULSE: v = 40;
                TP_CSEND:  v = 45;
                TP_ADEND:  v = 45;
                TP_DSET:   v = 25;
                TP_RCYC:   v = 55;
                TP_AACC:   v = 55;
                TP_OEACC:  v = 25;
                TP_FLOAT:  v = 20;
                default:   v = 0;
            endcase
        end else begin
            case (p)
                TP_WCYC:   v = 70;
                TP_WPULSE: v = 50;
                TP_CSEND:  v = 60;
                TP_ADEND:  v = 60;
                TP_DSET:   v = 30;
                TP_RCYC:   v = 70;
                TP_AACC:   v = 70;
                TP_OEACC:  v = 35;
                TP_FLOAT:  v = 25;
                default:   v = 0;
            endcase
        end
        return v;
    endfunction

    function automatic int unsigned cyc(int unsigned grade, tparam_e p, int unsigned clk_ns);
        return (grade_ns(grade, p) + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int unsigned umax(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned wp_cycles(int unsigned g, int unsigned t);
        return umax(umax(cyc(g, TP_WPULSE, t), cyc(g, TP_DSET, t)),
                    umax(umax(cyc(g, TP_CSEND, t), 1) - 1, umax(cyc(g, TP_ADEND, t), 1) - 1));
    endfunction

    function automatic int unsigned wr_cycles(int unsigned g, int unsigned t);
        int unsigned used;
        used = 1 + wp_cycles(g, t);
        return (cyc(g, TP_WCYC, t) > used + 1) ? cyc(g, TP_WCYC, t) - used : 1;
    endfunction

    function automatic int unsigned ra_cycles(int unsigned g, int unsigned t);
        return umax(1, umax(cyc(g, TP_AACC, t), cyc(g, TP_OEACC, t)));
    endfunction

    function automatic int unsigned rr_cycles(int unsigned g, int unsigned t);
        int unsigned rest;
        rest = (cyc(g, TP_RCYC, t) > ra_cycles(g, t)) ? cyc(g, TP_RCYC, t) - ra_cycles(g, t) : 0;
        return umax(1, umax(cyc(g, TP_FLOAT, t), rest));
    endfunction

    function automatic int unsigned rcv_cycles(int unsigned g, int unsigned t);
        return umax(1, cyc(g, TP_RCYC, t));
    endfunction

    function automatic pin_ctl_t pins_for(ctl_state_e s);
        pin_ctl_t p;
        p = PINS_PARKED;
        case (s)
            ST_WSETUP: begin p.cs1_n = 1'b0; p.cs2 = 1'b1; end
            ST_WPULSE: begin p.cs1_n = 1'b0; p.cs2 = 1'b1; p.we_n = 1'b0; p.dq_oe = 1'b1; end
            ST_RACC:   begin p.cs1_n = 1'b0; p.cs2 = 1'b1; p.oe_n = 1'b0; end
            default:   p = PINS_PARKED;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/sram_ctl_fsm.sv
module sram_ctl_fsm
    import sram_ctl_pkg::*;
#(
    parameter int unsigned WP_CYC  = 4,
    parameter int unsigned WR_CYC  = 1,
    parameter int unsigned RA_CYC  = 6,
    parameter int unsigned RR_CYC  = 2,
    parameter int unsigned RCV_CYC = 6,
    parameter int unsigned CNT_W   = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       req_valid,
    input  logic       req_write,
    input  logic       retain_req,
    output ctl_state_e state_q,
    output ctl_state_e state_d,
    output logic       accept,
    output logic       cap_strobe,
    output logic       op_done
);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             cnt_zero;

    assign cnt_zero = (cnt_q == '0);

    always_comb begin
        state_d    = state_q;
        cnt_d      = cnt_q;
        accept     = 1'b0;
        cap_strobe = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (retain_req) begin
                    state_d = ST_RETAIN;
                end else if (req_valid) begin
                    accept = 1'b1;
                    if (req_write) begin
                        state_d = ST_WSETUP;
                    end else begin
                        state_d = ST_RACC;
                        cnt_d   = CNT_W'(RA_CYC - 1);
                    end
                end
            end
            ST_WSETUP: begin
                state_d = ST_WPULSE;
                cnt_d   = CNT_W'(WP_CYC - 1);
            end
            ST_WPULSE: begin
                if (cnt_zero) begin
                    state_d = ST_WREC;
                    cnt_d   = CNT_W'(WR_CYC - 1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_WREC: begin
                if (cnt_zero) state_d = ST_IDLE;
                else          cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_RACC: begin
                if (cnt_zero) begin
                    cap_strobe = 1'b1;
                    state_d    = ST_RREC;
                    cnt_d      = CNT_W'(RR_CYC - 1);
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_RREC: begin
                if (cnt_zero) state_d = ST_IDLE;
                else          cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_RETAIN: begin
                if (!retain_req) begin
                    state_d = ST_RECOVER;
                    cnt_d   = CNT_W'(RCV_CYC - 1);
                end
            end
            ST_RECOVER: begin
                if (cnt_zero) state_d = ST_IDLE;
                else          cnt_d   = cnt_q - CNT_W'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign op_done = (state_d == ST_IDLE) && ((state_q == ST_WREC) || (state_q == ST_RREC));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

endmodule

// File: rtl/sram_ctl_pins.sv
module sram_ctl_pins
    import sram_ctl_pkg::*;
#(
    parameter int unsigned AW = 18,
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  ctl_state_e    state_d,
    input  logic          accept,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output pin_ctl_t      pins_q,
    output logic [AW-1:0] addr_q,
    output logic [DW-1:0] wdata_q
);

    pin_ctl_t pins_d;

    // Pins are registered from the next state so they change on the same
    // edge as the state register and never glitch.
    always_comb pins_d = pins_for(state_d);

    always_ff @(posedge clk) begin
        if (rst) begin
            pins_q  <= PINS_PARKED;
            addr_q  <= '0;
            wdata_q <= '0;
        end else begin
            pins_q <= pins_d;
            if (accept) begin
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
        end
    end

endmodule

// File: rtl/sram_ctl_rdcap.sv
module sram_ctl_rdcap #(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cap_strobe,
    input  logic          op_done,
    input  logic [DW-1:0] dq_in,
    output logic [DW-1:0] rdata_q,
    output logic          done_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= op_done;
            if (cap_strobe) rdata_q <= dq_in;
        end
    end

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned GRADE  = 1,
    parameter int unsigned AW     = 18,
    parameter int unsigned DW     = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    input  logic          retain_req,
    output logic          retained,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic [AW-1:0] mem_addr,
    output logic          mem_cs1_n,
    output logic          mem_cs2,
    output logic          mem_oe_n,
    output logic          mem_we_n,
    output logic [DW-1:0] mem_dq_out,
    output logic          mem_dq_oe,
    input  logic [DW-1:0] mem_dq_in
);

    localparam int unsigned WP_CYC  = wp_cycles(GRADE, CLK_NS);
    localparam int unsigned WR_CYC  = wr_cycles(GRADE, CLK_NS);
    localparam int unsigned RA_CYC  = ra_cycles(GRADE, CLK_NS);
    localparam int unsigned RR_CYC  = rr_cycles(GRADE, CLK_NS);
    localparam int unsigned RCV_CYC = rcv_cycles(GRADE, CLK_NS);
    localparam int unsigned MAX_CYC = umax(umax(WP_CYC, WR_CYC), umax(umax(RA_CYC, RR_CYC), RCV_CYC));
    localparam int unsigned CNT_W   = (MAX_CYC < 2) ? 1 : $clog2(MAX_CYC);

    ctl_state_e state_q, state_d;
    logic       accept, cap_strobe, op_done;
    pin_ctl_t   pins_q;

    sram_ctl_fsm #(
        .WP_CYC(WP_CYC), .WR_CYC(WR_CYC), .RA_CYC(RA_CYC),
        .RR_CYC(RR_CYC), .RCV_CYC(RCV_CYC), .CNT_W(CNT_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write), .retain_req(retain_req),
        .state_q(state_q), .state_d(state_d),
        .accept(accept), .cap_strobe(cap_strobe), .op_done(op_done)
    );

    sram_ctl_pins #(.AW(AW), .DW(DW)) u_pins (
        .clk(clk), .rst(rst),
        .state_d(state_d), .accept(accept),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .pins_q(pins_q), .addr_q(mem_addr), .wdata_q(mem_dq_out)
    );

    sram_ctl_rdcap #(.DW(DW)) u_rdcap (
        .clk(clk), .rst(rst),
        .cap_strobe(cap_strobe), .op_done(op_done),
        .dq_in(mem_dq_in), .rdata_q(rdata), .done_q(done)
    );

    assign mem_cs1_n = pins_q.cs1_n;
    assign mem_cs2   = pins_q.cs2;
    assign mem_oe_n  = pins_q.oe_n;
    assign mem_we_n  = pins_q.we_n;
    assign mem_dq_oe = pins_q.dq_oe;
    assign req_ready = (state_q == ST_IDLE);
    assign retained  = (state_q == ST_RETAIN);

endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_NS = 10,
    parameter int unsigned GRADE  = 1
) (
    input logic clk,
    input logic rst,
    input logic req_ready,
    input logic retained,
    input logic done,
    input logic mem_cs1_n,
    input logic mem_cs2,
    input logic mem_oe_n,
    input logic mem_we_n,
    input logic mem_dq_oe
);

    localparam int unsigned WP_MIN = cyc(GRADE, TP_WPULSE, CLK_NS);
    localparam int unsigned CW_MIN = cyc(GRADE, TP_CSEND, CLK_NS);

    logic        selected;
    logic [15:0] we_low_cnt, sel_cnt;

    assign selected = !mem_cs1_n && mem_cs2;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_cnt <= '0;
            sel_cnt    <= '0;
        end else begin
            we_low_cnt <= mem_we_n ? 16'd0 : we_low_cnt + 16'd1;
            sel_cnt    <= selected ? sel_cnt + 16'd1 : 16'd0;
        end
    end

    assert_reset_parks_R1: assert property (@(posedge clk)
        rst |=> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe && !done));

    assert_we_width_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_low_cnt >= 16'(WP_MIN)));

    assert_cs_window_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (sel_cnt >= 16'(CW_MIN)));

    assert_we_selected_R2: assert property (@(posedge clk) disable iff (rst)
        !mem_we_n |-> selected);

    assert_drive_in_write_R5: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n));

    assert_release_before_oe_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(mem_oe_n) |-> !$past(mem_dq_oe));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_idle_deselect_R6: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> !selected);

    assert_retain_parked_R8: assert property (@(posedge clk) disable iff (rst)
        retained |-> (mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe));

endmodule

bind sram_ctl sram_ctl_chk #(.CLK_NS(CLK_NS), .GRADE(GRADE)) u_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .retained(retained), .done(done),
    .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_oe(mem_dq_oe)
);

// File: tb/sram_ctl_bench.sv
module sram_ctl_bench;

    localparam int T = 10;

    function automatic int cdiv(int ns);
        return (ns + T - 1) / T;
    endfunction
    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

    // Expected cycle counts for the 55 ns grade, from the requirement formulas.
    localparam int WP_E  = imax(imax(cdiv(40), cdiv(25)), imax(cdiv(45) - 1, cdiv(45) - 1));
    localparam int WR_E  = imax(1, cdiv(55) - 1 - WP_E);
    localparam int RA_E  = imax(cdiv(55), cdiv(25));
    localparam int RR_E  = imax(1, imax(cdiv(20), cdiv(55) - RA_E));
    localparam int RCV_E = cdiv(55);

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, retain_req = 1'b0;
    logic [17:0] req_addr = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, retained, done;
    logic [7:0]  rdata;
    logic [17:0] mem_addr;
    logic        mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = 8'h00;

    always #5 clk = ~clk;

    sram_ctl u_sram_ctl (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .retain_req(retain_req), .retained(retained),
        .done(done), .rdata(rdata),
        .mem_addr(mem_addr), .mem_cs1_n(mem_cs1_n), .mem_cs2(mem_cs2),
        .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    int checks = 0;
    int fails  = 0;

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
        end
    endtask

    // Memory model: unwritten bytes read as FF; drives only when selected with OE low.
    logic [7:0] model_mem [logic [17:0]];
    logic [7:0] exp_mem   [logic [17:0]];

    always @(negedge clk) begin
        if (!mem_cs1_n && mem_cs2 && !mem_we_n && mem_dq_oe)
            model_mem[mem_addr] = mem_dq_out;
        if (!mem_cs1_n && mem_cs2 && mem_we_n && !mem_oe_n)
            mem_dq_in = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 8'hFF;
        else
            mem_dq_in = 8'hC3;
    end

    // Scoreboard
    typedef struct { bit is_rd; logic [7:0] data; } sb_item_t;
    sb_item_t sb_q[$];

    logic prev_done = 1'b0;
    logic prev_we_n = 1'b1;
    int   we_run = 0;

    always @(negedge clk) begin
        if (!rst) begin
            if (done) begin
                if (sb_q.size() == 0) begin
                    chk(1'b0, "R6 unexpected done", 1, 0);
                end else begin
                    sb_item_t it;
                    it = sb_q.pop_front();
                    if (it.is_rd) chk(rdata == it.data, "R4 read data", rdata, it.data);
                end
            end
            if (done && prev_done) chk(1'b0, "R6 done longer than one cycle", 2, 1);
            if (mem_dq_oe && (mem_we_n || !mem_oe_n))
                chk(1'b0, "R5 bus driven outside write strobe", 1, 0);
            if (!mem_we_n && !(!mem_cs1_n && mem_cs2))
                chk(1'b0, "R2 strobe without select", 1, 0);
            if (mem_we_n && !prev_we_n) chk(we_run == WP_E, "R2 strobe width", we_run, WP_E);
            we_run = mem_we_n ? 0 : we_run + 1;
        end
        prev_done = done;
        prev_we_n = mem_we_n;
    end

    task automatic do_op(input bit wr, input logic [17:0] a, input logic [7:0] d, input bit spurious);
        sb_item_t it;
        int lat;
        int exp_lat;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        it.is_rd = !wr;
        it.data  = exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
        if (wr) exp_mem[a] = d;
        sb_q.push_back(it);
        @(negedge clk);
        if (spurious) begin
            // R6: keep a different write request asserted while busy
            chk(req_ready == 1'b0, "R6 ready low while busy", req_ready, 0);
            req_write = 1'b1; req_addr = a ^ 18'h1; req_wdata = ~d;
        end else begin
            req_valid = 1'b0;
        end
        lat = 0;
        while (!done && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        req_valid = 1'b0;
        exp_lat = wr ? (1 + WP_E + WR_E) : (RA_E + RR_E);
        chk(lat == exp_lat, wr ? "R3 write latency" : "R4 read latency", lat, exp_lat);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        int lat;
        logic [7:0] held;
        repeat (3) @(negedge clk);
        // R1: reset state while reset is high
        chk(mem_cs1_n && !mem_cs2 && mem_oe_n && mem_we_n && !mem_dq_oe, "R1 pins in reset",
            {mem_cs1_n, mem_cs2, mem_oe_n, mem_we_n, mem_dq_oe}, 5'b10110);
        rst = 1'b0;
        @(negedge clk);
        chk(!done && !retained && req_ready, "R1 outputs after reset", {done, retained, req_ready}, 3'b001);

        // R2, R3: writes across the address range and data patterns
        do_op(1'b1, 18'h00000, 8'hA5, 1'b0);
        do_op(1'b1, 18'h3FFFF, 8'h3C, 1'b0);
        do_op(1'b1, 18'h12345, 8'h00, 1'b0);
        do_op(1'b1, 18'h2AAAA, 8'hFF, 1'b0);
        do_op(1'b1, 18'h00055, 8'h11, 1'b0);

        // R4: read back
        do_op(1'b0, 18'h3FFFF, 8'h00, 1'b0);
        do_op(1'b0, 18'h00000, 8'h00, 1'b0);
        do_op(1'b0, 18'h12345, 8'h00, 1'b0);
        do_op(1'b0, 18'h2AAAA, 8'h00, 1'b0);
        do_op(1'b0, 18'h01000, 8'h00, 1'b0);

        // R7: rdata holds across a write
        do_op(1'b0, 18'h3FFFF, 8'h00, 1'b0);
        held = rdata;
        do_op(1'b1, 18'h00100, 8'h77, 1'b0);
        chk(rdata == held, "R7 rdata held over write", rdata, held);
        chk(held == 8'h3C, "R7 held value", held, 8'h3C);

        // R6: request held during busy starts nothing (0x57 must stay unwritten)
        do_op(1'b1, 18'h00056, 8'h5E, 1'b1);
        do_op(1'b0, 18'h00057, 8'h00, 1'b0);
        do_op(1'b0, 18'h00056, 8'h00, 1'b0);

        // R8: retention wins over a simultaneous write
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        retain_req = 1'b1;
        req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00055; req_wdata = 8'hEE;
        @(negedge clk);
        chk(retained == 1'b1, "R8 retained after one edge", retained, 1);
        chk(mem_cs1_n && !mem_cs2, "R8 deselected", {mem_cs1_n, mem_cs2}, 2'b10);
        chk(req_ready == 1'b0, "R8 ready low in retention", req_ready, 0);
        repeat (4) @(negedge clk);
        chk(retained == 1'b1, "R8 retention held", retained, 1);
        retain_req = 1'b0; req_valid = 1'b0;
        @(negedge clk);
        chk(retained == 1'b0, "R9 retained clears", retained, 0);
        lat = 1;
        while (!req_ready && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        // R9: ready returns RCV edges after the first edge seeing the drop
        chk(lat == RCV_E + 1, "R9 recovery length", lat, RCV_E + 1);
        do_op(1'b0, 18'h00055, 8'h00, 1'b0);
        chk(rdata == 8'h11, "R8 dropped write left data", rdata, 8'h11);

        // back-to-back mixed traffic
        do_op(1'b1, 18'h15555, 8'h96, 1'b0);
        do_op(1'b0, 18'h15555, 8'h00, 1'b0);
        repeat (3) @(negedge clk);
        chk(sb_q.size() == 0, "R6 every request completed", sb_q.size(), 0);
        finish_run();
    end

endmodule